// File: doc/BRIEF.md
# Accumulator Instruction Sequencer

This block is the control sequencer of a small 8-bit accumulator machine. It runs every instruction as a fixed four-step cycle. The first step fetches an opcode from memory into an instruction register. The second copies the accumulator into the first ALU operand register. The third reads a memory byte into the second ALU operand register. The fourth applies the decoded ALU function and writes the result back into the accumulator.

The step is held as a ring of flip-flops in which exactly one bit is high. Each stage has a two-input multiplexer in front of it. The multiplexer either passes the previous stage's bit along the ring or forces a fixed value, so the ring can be sent straight back to the fetch step. That forcing path serves a synchronous restart, and it also drops opcodes that are outside the ALU group.

The opcode is split into three fixed fields: a group marker, an operand-source field and an ALU-operation field. The program counter starts at a parameter address and advances by one for each byte taken from the instruction stream.

Top module: `acc_seq_core`

## Requirements
- R1: While `rst_n` is low, and at once when it falls, the step is fetch (`state` = 4'b0001), `acc` is 0x00 and `mem_addr` equals the parameter `RESET_PC` (default 0x10).
- R2: Exactly one bit of `state` is high at all times. Bit i marks step i, where 0 is fetch, 1 is load operand A, 2 is load operand B and 3 is execute. Without forcing, the high bit moves from i to i+1 on each clock, and from 3 back to 0.
- R3: In the fetch step, `mem_rd` is high and `mem_addr` is the program counter. The byte on `mem_rdata` is captured as the opcode, and the program counter then advances by one.
- R4: An opcode is in the ALU group when bits 1..0 are 2'b01. Any other opcode is a no-op: the next step is fetch again, and `acc` is unchanged.
- R5: Opcode bits 4..2 choose the operand source. The value 3'b010 reads the byte at the program counter in step 2 and advances the counter by one. Any other value v reads address v (zero-extended) and leaves the counter unchanged.
- R6: Opcode bits 7..5 choose the ALU operation that the execute step writes to `acc`. The operand A register holds the accumulator copy and the operand B register holds the memory byte. The codes are: 0 A|B, 1 A&B, 2 A^B, 3 A+B mod 256, 4 B, 5 A-B mod 256, 6 A shifted left by one, 7 A shifted right by one (logical).
- R7: `acc` changes only on the clock edge that ends the execute step. In steps 0 to 2 it holds its value.
- R8: `mem_rd` is high in the fetch step and in the operand B step, and low in the other two steps.
- R9: A high `restart` at a clock edge forces the fetch step and loads the program counter with `RESET_PC`. It does this in any step. In the execute step it also blocks the write to `acc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous return to fetch at `RESET_PC` |
| mem_rdata | input | DATA_W (8) | Memory read data, valid in the same cycle as `mem_addr` |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W (8) | Memory read address |
| acc | output | DATA_W (8) | Accumulator |
| state | output | 4 | One-hot step indicator |

## Verification
The assertions assume that memory answers with no latency: `mem_rdata` is the byte at `mem_addr` within the same cycle. They also assume that `restart` and `mem_rdata` are never unknown while reset is released. The bench models memory as a combinational array that it fills before reset is released. It changes inputs only on falling edges. It places the program above the eight low slot addresses, so slot-mode operands never overlap the instruction stream.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

  typedef enum logic [2:0] {
    OP_OR  = 3'd0,
    OP_AND = 3'd1,
    OP_XOR = 3'd2,
    OP_ADD = 3'd3,
    OP_LDB = 3'd4,
    OP_SUB = 3'd5,
    OP_SHL = 3'd6,
    OP_SHR = 3'd7
  } alu_op_e;

  localparam logic [1:0] GROUP_ALU = 2'b01;
  localparam logic [2:0] MODE_IMM  = 3'b010;
  localparam int         OPC_W     = 8;

  localparam int NUM_ST   = 4;
  localparam int ST_FETCH = 0;
  localparam int ST_LDA   = 1;
  localparam int ST_LDB   = 2;
  localparam int ST_EXEC  = 3;

  typedef struct packed {
    alu_op_e    op;
    logic [2:0] mode;
    logic       alu_grp;
  } dec_t;

endpackage

// File: rtl/acc_seq_decode.sv
module acc_seq_decode
  import acc_seq_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output dec_t             dec
);

  always_comb begin
    dec.op      = alu_op_e'(opc[7:5]);
    dec.mode    = opc[4:2];
    dec.alu_grp = (opc[1:0] == GROUP_ALU);
  end

endmodule

// File: rtl/acc_seq_alu.sv
module acc_seq_alu
  import acc_seq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y
);

  always_comb begin
    unique case (op)
      OP_OR:   y = a | b;
      OP_AND:  y = a & b;
      OP_XOR:  y = a ^ b;
      OP_ADD:  y = a + b;
      OP_LDB:  y = b;
      OP_SUB:  y = a - b;
      OP_SHL:  y = {a[W-2:0], 1'b0};
      OP_SHR:  y = {1'b0, a[W-1:1]};
      default: y = a;
    endcase
  end

endmodule

// File: rtl/acc_seq_ring.sv
module acc_seq_ring #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         force_start,
  output logic [N-1:0] st_q
);

  logic [N-1:0] st_d;

  for (genvar i = 0; i < N; i++) begin : g_stage
    localparam int   PREV   = (i == 0) ? N - 1 : i - 1;
    localparam logic FORCED = (i == 0);

    // stage multiplexer: pass ring neighbour or forced value
    assign st_d[i] = force_start ? FORCED : st_q[PREV];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q[i] <= FORCED;
      else        st_q[i] <= st_d[i];
    end
  end

  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(st_q) == 1);

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !force_start |=> st_q == {$past(st_q[N-2:0]), $past(st_q[N-1])});

  assert_force_R2: assert property (@(posedge clk) disable iff (!rst_n)
    force_start |=> st_q[0]);

endmodule

// File: rtl/acc_seq_core.sv
module acc_seq_core
  import acc_seq_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] RESET_PC = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] acc,
  output logic [NUM_ST-1:0] state
);

  logic [NUM_ST-1:0] st_q;
  logic              force_start;
  dec_t              fetch_dec, ir_dec;
  logic              imm_mode;

  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [OPC_W-1:0]  ir_q, ir_d;
  logic [DATA_W-1:0] opa_q, opa_d;
  logic [DATA_W-1:0] opb_q, opb_d;
  logic [DATA_W-1:0] acc_q, acc_d;
  logic [DATA_W-1:0] alu_y;
  logic              pc_en, ir_en, opa_en, opb_en, acc_en;

  acc_seq_ring #(.N(NUM_ST)) u_ring (
    .clk         (clk),
    .rst_n       (rst_n),
    .force_start (force_start),
    .st_q        (st_q)
  );

  acc_seq_decode u_dec_fetch (
    .opc (mem_rdata[OPC_W-1:0]),
    .dec (fetch_dec)
  );

  acc_seq_decode u_dec_ir (
    .opc (ir_q),
    .dec (ir_dec)
  );

  acc_seq_alu #(.W(DATA_W)) u_alu (
    .a  (opa_q),
    .b  (opb_q),
    .op (ir_dec.op),
    .y  (alu_y)
  );

  assign imm_mode    = (ir_dec.mode == MODE_IMM);
  assign force_start = restart | (st_q[ST_FETCH] & ~fetch_dec.alu_grp);

  assign mem_rd   = st_q[ST_FETCH] | st_q[ST_LDB];
  assign mem_addr = (st_q[ST_LDB] && !imm_mode) ? ADDR_W'(ir_dec.mode) : pc_q;

  // next-state and enables
  always_comb begin
    pc_en  = restart | st_q[ST_FETCH] | (st_q[ST_LDB] & imm_mode);
    pc_d   = restart ? RESET_PC : pc_q + ADDR_W'(1);
    ir_en  = st_q[ST_FETCH] & ~restart;
    ir_d   = mem_rdata[OPC_W-1:0];
    opa_en = st_q[ST_LDA] & ~restart;
    opa_d  = acc_q;
    opb_en = st_q[ST_LDB] & ~restart;
    opb_d  = mem_rdata;
    acc_en = st_q[ST_EXEC] & ~restart;
    acc_d  = alu_y;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= RESET_PC;
      ir_q  <= '0;
      opa_q <= '0;
      opb_q <= '0;
      acc_q <= '0;
    end else begin
      if (pc_en)  pc_q  <= pc_d;
      if (ir_en)  ir_q  <= ir_d;
      if (opa_en) opa_q <= opa_d;
      if (opb_en) opb_q <= opb_d;
      if (acc_en) acc_q <= acc_d;
    end
  end

  assign acc   = acc_q;
  assign state = st_q;

  assert_fetch_pc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st_q[ST_FETCH] && !restart |=> pc_q == $past(pc_q) + ADDR_W'(1));

  assert_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st_q[ST_FETCH] && !fetch_dec.alu_grp |=> st_q[ST_FETCH] && $stable(acc_q));

  assert_slot_pc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    st_q[ST_LDB] && !restart && !imm_mode |=> pc_q == $past(pc_q));

  assert_acc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !st_q[ST_EXEC] |=> $stable(acc_q));

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> st_q[ST_FETCH] && (pc_q == RESET_PC) && $stable(acc_q));

endmodule

// File: tb/test_acc_seq_core.sv
module test_acc_seq_core;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  // {opcode, immediate operand}; opcodes use immediate mode (bits 4..2 = 010)
  localparam logic [15:0] VEC [NV] = '{
    16'h893C, 16'h0941, 16'h290F, 16'h49FF, 16'h6920,
    16'hA913, 16'hC900, 16'hE900, 16'h8980, 16'h6980
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       restart;
  logic [7:0] mem_rdata;
  logic       mem_rd;
  logic [7:0] mem_addr;
  logic [7:0] acc;
  logic [3:0] state;
  logic [7:0] mem [256];

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign mem_rdata = mem[mem_addr];

  acc_seq_core i_acc_seq_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .mem_rdata (mem_rdata),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .acc       (acc),
    .state     (state)
  );

  function automatic logic [7:0] model(input logic [7:0] a, input logic [7:0] opc,
                                       input logic [7:0] b);
    case (opc[7:5])
      3'd0: model = a | b;
      3'd1: model = a & b;
      3'd2: model = a ^ b;
      3'd3: model = a + b;
      3'd4: model = b;
      3'd5: model = a - b;
      3'd6: model = a << 1;
      default: model = a >> 1;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_main();
    logic [7:0] exp_acc = 8'h00;
    logic [7:0] pc = 8'h10;
    // reset state, R1
    @(negedge clk); @(negedge clk);
    check(state == 4'b0001, "R1 reset state", state, 4'b0001);
    check(acc == 8'h00, "R1 reset acc", acc, 0);
    check(mem_addr == 8'h10, "R1 reset pc", mem_addr, 8'h10);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic [7:0] nxt = model(exp_acc, VEC[v][15:8], VEC[v][7:0]);
      bit seq_ok = 1, rd_ok = 1, hold_ok = 1;
      check(mem_addr == pc, "R3 fetch address", mem_addr, pc);
      for (int k = 0; k < 4; k++) begin
        if (state != (4'b0001 << k)) seq_ok = 0;
        if (mem_rd != (k == 0 || k == 2)) rd_ok = 0;
        if (acc != exp_acc) hold_ok = 0;
        @(negedge clk);
      end
      check(seq_ok, "R2 step order", state, 4'b0001);
      check(rd_ok, "R8 read strobe steps", mem_rd, 1);
      check(hold_ok, "R7 acc held before execute", acc, exp_acc);
      check(acc == nxt, "R6 alu result", acc, nxt);
      exp_acc = nxt;
      pc = pc + 8'd2;
    end

    // no-op opcode at 0x24, R4
    @(negedge clk);
    check(state == 4'b0001, "R4 no-op returns to fetch", state, 4'b0001);
    check(acc == exp_acc, "R4 no-op leaves acc", acc, exp_acc);
    check(mem_addr == 8'h25, "R3 no-op pc advance", mem_addr, 8'h25);

    // slot-mode ADD at 0x25 reading address 1, R5
    repeat (2) @(negedge clk);
    check(state == 4'b0100 && mem_addr == 8'h01, "R5 slot address", mem_addr, 8'h01);
    repeat (2) @(negedge clk);
    exp_acc = model(exp_acc, 8'h65, 8'h05);
    check(acc == exp_acc, "R5 slot operand result", acc, exp_acc);
    check(mem_addr == 8'h26, "R5 slot pc unchanged", mem_addr, 8'h26);

    // restart in execute step, R9
    repeat (3) @(negedge clk);
    check(state == 4'b1000, "R2 execute step reached", state, 4'b1000);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    check(state == 4'b0001, "R9 restart to fetch", state, 4'b0001);
    check(mem_addr == 8'h10, "R9 restart pc", mem_addr, 8'h10);
    check(acc == exp_acc, "R9 restart blocks write", acc, exp_acc);

    // asynchronous reset mid-instruction, R1
    repeat (2) @(negedge clk);
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    check(acc == 8'h00, "R1 async reset acc", acc, 0);
    check(state == 4'b0001, "R1 async reset state", state, 4'b0001);
    check(mem_addr == 8'h10, "R1 async reset pc", mem_addr, 8'h10);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    rst_n   = 1'b0;
    restart = 1'b0;
    for (int a = 0; a < 256; a++) mem[a] = 8'h00;
    for (int v = 0; v < NV; v++) begin
      mem[8'h10 + 2*v]     = VEC[v][15:8];
      mem[8'h10 + 2*v + 1] = VEC[v][7:0];
    end
    mem[8'h24] = 8'h02;   // low bits 10: not ALU group
    mem[8'h25] = 8'h65;   // ADD, slot 1
    mem[8'h01] = 8'h05;
    mem[8'h26] = 8'h09;   // OR immediate
    mem[8'h27] = 8'hF0;

    fork
      run_main();
      begin
        #(CLK_PERIOD * 5000);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule